// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block produces the word addresses for a multi-register memory transfer. A single-cycle start pulse captures a base address, a 16-bit register-select mask and four mode flags: load or store, upward or downward addressing, step before or after each access, and base writeback. The block then emits one beat per selected register on a valid/ready port. Each beat carries the register number and the word address for that register.

Registers always leave in ascending index order, and the lowest-numbered register always gets the lowest address. For downward addressing the block first works out the bottom of the block from the register count, then walks upward. The four stack disciplines map onto the flags like this:

- full descending: down, before
- empty descending: down, after
- full ascending: up, before
- empty ascending: up, after

When the last beat has been accepted, a one-cycle done pulse appears. The updated base and a flag for a load that included the top register (the program counter) are presented with it and held until the next start.

Finite-state machine:

- States: `S_IDLE`, `S_ISSUE`, `S_FINISH`.
- `S_IDLE` → `S_ISSUE`: on start with a non-empty mask.
- `S_IDLE` → `S_FINISH`: on start with an empty mask.
- `S_ISSUE` → `S_ISSUE`: on each accepted beat that is not the last.
- `S_ISSUE` → `S_FINISH`: on the last accepted beat.
- `S_FINISH` → `S_IDLE`: always, after one cycle.

Top module: `blk_xfer_addr_seq`

## Requirements
- R1: One beat is issued per set mask bit, in ascending register index order, whatever the direction flag; bit i of the mask selects register i.
- R2: Beat addresses are word aligned: the two low bits of the base are treated as zero. Successive beats step by +4.
- R3: Upward, step-after (`go_up`=1, `step_first`=0): the first beat address equals the base.
- R4: Upward, step-before (`go_up`=1, `step_first`=1): the first beat address is base+4.
- R5: Downward, step-after (`go_up`=0, `step_first`=0): the first beat address is base−4×count+4, where count is the number of set mask bits.
- R6: Downward, step-before (`go_up`=0, `step_first`=1): the first beat address is base−4×count.
- R7: With `wb_en`=1, `new_base` is base+4×count when upward and base−4×count when downward. With `wb_en`=0 it is the aligned base. Addresses wrap modulo 2^32.
- R8: `pc_loaded` is 1 exactly when `is_load`=1 and mask bit 15 is set.
- R9: While `beat_valid` is high and `beat_ready` is low, the beat's register and address stay unchanged. A beat completes only on a clock edge where both are high.
- R10: `done` is high for exactly one cycle, the cycle after the last beat is accepted. `new_base` and `pc_loaded` are valid from then until the next start.
- R11: An all-zero mask issues no beats. `done` is high in the cycle after start, with `new_base` equal to the base even when `wb_en`=1, and `pc_loaded`=0.
- R12: A start pulse while `busy` is high is ignored: the beats and results of the running transfer are unaffected.
- R13: After reset, `beat_valid`, `done` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a transfer (sampled while idle) |
| base_addr | input | 32 | Base address |
| reg_mask | input | 16 | Register-select mask |
| is_load | input | 1 | 1 = load, 0 = store |
| go_up | input | 1 | 1 = upward addressing, 0 = downward |
| step_first | input | 1 | 1 = step before access, 0 = after |
| wb_en | input | 1 | Base writeback enable |
| beat_valid | output | 1 | Beat available |
| beat_ready | input | 1 | Consumer accepts beat |
| beat_reg | output | 4 | Register index of the beat |
| beat_addr | output | 32 | Word address of the beat |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| new_base | output | 32 | Updated base value |
| pc_loaded | output | 1 | A load included register 15 |

## Verification
The hardest situation to reach is a start pulse arriving mid-transfer while the consumer is stalling. The stimulus holds `beat_ready` low on the first beat, pulses start with a different base and mask, then releases ready. It confirms that the original register sequence and final base come out. The downward wrap below address zero is a second awkward case. A full mask against a small base drives the lowest address past zero, which checks the modulo arithmetic of R5 and R7. Stalls on every other beat exercise R9 in every mode.

// File: rtl/bxs_pkg.sv
package bxs_pkg;
    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_ISSUE  = 2'd1,
        S_FINISH = 2'd2
    } seq_state_t;
endpackage

// File: rtl/bxs_popcount.sv
module bxs_popcount #(
    parameter int WIDTH = 16,
    localparam int CW = $clog2(WIDTH + 1)
) (
    input  logic [WIDTH-1:0] vec,
    output logic [CW-1:0]    count
);
    always_comb begin
        count = '0;
        for (int i = 0; i < WIDTH; i++) begin
            count = count + CW'(vec[i]);
        end
    end
endmodule

// File: rtl/bxs_lowest_pick.sv
module bxs_lowest_pick #(
    parameter int WIDTH = 16,
    localparam int IW = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] vec,
    output logic [IW-1:0]    idx
);
    // scan downward so the lowest set bit is the last one written
    always_comb begin
        idx = '0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/blk_xfer_addr_seq.sv
module blk_xfer_addr_seq
    import bxs_pkg::*;
#(
    parameter int REGS       = 16,
    parameter int AW         = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [AW-1:0]           base_addr,
    input  logic [REGS-1:0]         reg_mask,
    input  logic                    is_load,
    input  logic                    go_up,
    input  logic                    step_first,
    input  logic                    wb_en,
    output logic                    beat_valid,
    input  logic                    beat_ready,
    output logic [$clog2(REGS)-1:0] beat_reg,
    output logic [AW-1:0]           beat_addr,
    output logic                    busy,
    output logic                    done,
    output logic [AW-1:0]           new_base,
    output logic                    pc_loaded
);
    localparam int IDX_W = $clog2(REGS);
    localparam int CNT_W = $clog2(REGS + 1);
    localparam int SH    = $clog2(WORD_BYTES);
    localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

    seq_state_t          state, nxt;
    logic [REGS-1:0]     pend_q, rest;
    logic [AW-1:0]       cur_addr_q, nb_q;
    logic                pc_q;
    logic [CNT_W-1:0]    sel_cnt;
    logic [IDX_W-1:0]    pick_idx;
    logic [AW-1:0]       aligned, span, first_addr, final_base;

    bxs_popcount #(.WIDTH(REGS)) u_count (
        .vec   (reg_mask),
        .count (sel_cnt)
    );

    bxs_lowest_pick #(.WIDTH(REGS)) u_pick (
        .vec (pend_q),
        .idx (pick_idx)
    );

    // start-time address arithmetic
    always_comb begin
        aligned = base_addr & ~(STEP - AW'(1));
        span    = {{(AW-CNT_W){1'b0}}, sel_cnt} << SH;
        if (go_up) begin
            first_addr = step_first ? aligned + STEP : aligned;
        end else begin
            first_addr = step_first ? aligned - span : aligned - span + STEP;
        end
        if (wb_en) begin
            final_base = go_up ? aligned + span : aligned - span;
        end else begin
            final_base = aligned;
        end
    end

    assign rest = pend_q & ~(REGS'(1) << pick_idx);

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   if (start) nxt = (reg_mask == '0) ? S_FINISH : S_ISSUE;
            S_ISSUE:  if (beat_ready && rest == '0) nxt = S_FINISH;
            S_FINISH: nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q     <= '0;
            cur_addr_q <= '0;
            nb_q       <= '0;
            pc_q       <= 1'b0;
        end else if (state == S_IDLE && start) begin
            pend_q     <= reg_mask;
            cur_addr_q <= first_addr;
            nb_q       <= final_base;
            pc_q       <= is_load & reg_mask[REGS-1];
        end else if (state == S_ISSUE && beat_ready) begin
            pend_q     <= rest;
            cur_addr_q <= cur_addr_q + STEP;
        end
    end

    // outputs
    always_comb begin
        beat_valid = 1'b0;
        done       = 1'b0;
        busy       = 1'b1;
        unique case (state)
            S_IDLE:   busy = 1'b0;
            S_ISSUE:  beat_valid = 1'b1;
            S_FINISH: done = 1'b1;
            default:  busy = 1'b0;
        endcase
        beat_reg  = pick_idx;
        beat_addr = cur_addr_q;
        new_base  = nb_q;
        pc_loaded = pc_q;
    end

    assert_word_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> beat_addr[SH-1:0] == '0);

    assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_ready) |=> (!beat_valid || beat_addr == $past(beat_addr) + STEP));

    assert_reg_ascending_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_ready) |=> (!beat_valid || beat_reg > $past(beat_reg)));

    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_ready) |=> (beat_valid && $stable(beat_addr) && $stable(beat_reg)));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !beat_valid));

    assert_busy_results_R12: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(new_base) && $stable(pc_loaded)));
endmodule

// File: tb/blk_xfer_addr_seq_test.sv
`timescale 1ns/1ps
module blk_xfer_addr_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] base_addr = '0;
    logic [15:0] reg_mask = '0;
    logic        is_load = 1'b0, go_up = 1'b0, step_first = 1'b0, wb_en = 1'b0;
    logic        beat_valid, beat_ready = 1'b0;
    logic [3:0]  beat_reg;
    logic [31:0] beat_addr, new_base;
    logic        busy, done, pc_loaded;

    int total = 0;
    int fails = 0;

    always #2 clk = ~clk;

    blk_xfer_addr_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .reg_mask(reg_mask), .is_load(is_load), .go_up(go_up),
        .step_first(step_first), .wb_en(wb_en), .beat_valid(beat_valid),
        .beat_ready(beat_ready), .beat_reg(beat_reg), .beat_addr(beat_addr),
        .busy(busy), .done(done), .new_base(new_base), .pc_loaded(pc_loaded)
    );

    // {base, mask, load, up, before, wb, first_addr, new_base, pc}
    localparam logic [116:0] TBL [7] = '{
        {32'h0000_1000, 16'h00FF, 1'b0, 1'b1, 1'b0, 1'b1, 32'h0000_1000, 32'h0000_1020, 1'b0},
        {32'h0000_2000, 16'h8001, 1'b1, 1'b1, 1'b1, 1'b1, 32'h0000_2004, 32'h0000_2008, 1'b1},
        {32'h0000_3000, 16'h0F00, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0000_2FF0, 32'h0000_2FF0, 1'b0},
        {32'h0000_4000, 16'h0030, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_3FFC, 32'h0000_4000, 1'b0},
        {32'h0000_0010, 16'hFFFF, 1'b1, 1'b0, 1'b0, 1'b1, 32'hFFFF_FFD4, 32'hFFFF_FFD0, 1'b1},
        {32'h0000_5000, 16'h8000, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_5000, 32'h0000_5000, 1'b0},
        {32'h0000_1003, 16'h0001, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0000_1000, 32'h0000_1000, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue_start(input logic [31:0] b, input logic [15:0] m,
                               input logic l, input logic u, input logic s, input logic w);
        base_addr = b; reg_mask = m; is_load = l; go_up = u; step_first = s; wb_en = w;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_xfer(input logic [116:0] v, input bit inject);
        logic [15:0] m;
        logic [31:0] first, exp_nb;
        logic        u, s;
        int          k;
        string       tag;
        m = v[84:69]; u = v[67]; s = v[66]; first = v[64:33]; exp_nb = v[32:1];
        if (u && !s)      tag = "R3";
        else if (u && s)  tag = "R4";
        else if (!s)      tag = "R5";
        else              tag = "R6";
        issue_start(v[116:85], m, v[68], u, s, v[65]);
        k = 0;
        for (int i = 0; i < 16; i++) begin
            if (m[i]) begin
                for (int t = 0; t < 20 && !beat_valid; t++) @(negedge clk);
                chk(beat_valid && beat_reg == 4'(i), "R1 reg", 32'(beat_reg), 32'(i));
                chk(beat_addr == first + 32'(4 * k), (k == 0) ? tag : "R2",
                    beat_addr, first + 32'(4 * k));
                if (inject && k == 0) begin
                    issue_start(32'h0000_9000, 16'h0001, 1'b1, 1'b0, 1'b1, 1'b1);
                    chk(beat_valid && beat_reg == 4'(i), "R12 beat kept", 32'(beat_reg), 32'(i));
                end
                if (k % 2 == 1) begin
                    @(negedge clk);
                    chk(beat_valid && beat_addr == first + 32'(4 * k), "R9 stall hold",
                        beat_addr, first + 32'(4 * k));
                end
                beat_ready = 1'b1;
                @(negedge clk);
                beat_ready = 1'b0;
                k++;
            end
        end
        chk(done && !beat_valid, "R10 done after last", 32'(done), 32'd1);
        chk(new_base == exp_nb, "R7 new base", new_base, exp_nb);
        chk(pc_loaded == v[0], "R8 pc flag", 32'(pc_loaded), 32'(v[0]));
        @(negedge clk);
        chk(!done && !busy, "R10 one-cycle done", 32'(done), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!beat_valid && !done && !busy, "R13 reset state", {29'd0, beat_valid, done, busy}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!beat_valid && !done && !busy, "R13 after release", {29'd0, beat_valid, done, busy}, 32'd0);

        for (int n = 0; n < 7; n++) run_xfer(TBL[n], 1'b0);

        // R12: start during a stalled transfer
        run_xfer({32'h0000_6000, 16'h0006, 1'b0, 1'b1, 1'b0, 1'b1,
                  32'h0000_6000, 32'h0000_6008, 1'b0}, 1'b1);

        // R11: empty mask
        issue_start(32'h0000_7000, 16'h0000, 1'b1, 1'b1, 1'b1, 1'b1);
        chk(done && !beat_valid, "R11 immediate done", 32'(done), 32'd1);
        chk(new_base == 32'h0000_7000, "R11 base unchanged", new_base, 32'h0000_7000);
        chk(!pc_loaded, "R11 no pc flag", 32'(pc_loaded), 32'd0);
        @(negedge clk);
        chk(!done && !beat_valid, "R11 no beats", {30'd0, done, beat_valid}, 32'd0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule